// File: doc/BRIEF.md
# Segmented Memory Access Sequencer

This block takes one logical memory access and carries it out as a series of byte transfers on an 8-bit external bus. A logical access is made of a 16-bit segment value, a 16-bit offset, a size code and a direction. The block forms the 20-bit physical address by placing the segment four bit positions higher and adding the offset. It then walks the bytes of the access in rising address order, one transfer per bus handshake. Each byte has its own address. The offset is advanced with 16-bit wrap inside the segment, and the 20-bit sum wraps as well. On reads, the returned bytes are packed little-endian into a 32-bit result. At accept time the block also reports whether the access starts on an even physical address.

Both the request side and the byte bus use valid/ready handshakes.

- **Request side:** a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle.
- **Byte bus:** the block holds `bus_valid` high with a steady address, direction and write byte until the edge on which `bus_ready` is also high. The bus may stall for any number of cycles.
- **Completion:** `done` pulses for one cycle after the last byte. In that same cycle the block is idle again.

Top module: `seg_access_seq`

## Requirements
- R1: The physical address of the first byte is ({segment, 4'b0000} + zero-extended offset) modulo 2^20; segment 1234h with offset 0022h gives 12362h.
- R2: Size code 0 (byte) makes one transfer, code 1 (word) two, code 2 (doubleword) four; code 3 behaves as a byte.
- R3: Byte k of an access uses offset (offset + k) modulo 2^16 with the same segment, so transfers come in rising offset order and the offset wraps from FFFFh to 0000h inside the segment.
- R4: On a write, byte k carries `req_wdata[8k+7:8k]` (least significant byte at the lowest address); a pointer with offset 55FFh and segment A000h written as doubleword data A00055FFh at 0000:0008 puts FFh, 55h, 00h, A0h at 00008h..0000Bh.
- R5: On a read, the byte returned for transfer k lands in `rdata[8k+7:8k]`; `rdata` is cleared at each accept, so bytes beyond the access size read as zero, and writes leave it zero.
- R6: While `bus_valid` is high and `bus_ready` low, the address, direction and write byte stay unchanged and no byte is counted.
- R7: `req_ready` is high exactly when the block is idle; a request presented while the block is busy is ignored and does not disturb the access in flight.
- R8: `done` is high for exactly one cycle, the cycle after the handshake of the last byte; in that cycle `bus_valid` is low and `req_ready` is high.
- R9: `aligned` is set at accept to 1 for a byte access and to the inverse of bit 0 of the first physical address for word and doubleword; it holds that value until the next accept.
- R10: After reset `req_ready` is 1, `bus_valid` and `done` are 0, `rdata` is 0 and `aligned` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request will be taken |
| req_seg | input | 16 | Segment value |
| req_off | input | 16 | Offset value |
| req_size | input | 2 | 0 byte, 1 word, 2 doubleword, 3 as byte |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data, little-endian |
| bus_valid | output | 1 | Byte transfer offered |
| bus_ready | input | 1 | Byte transfer taken |
| bus_addr | output | 20 | Physical byte address |
| bus_write | output | 1 | Transfer direction |
| bus_wdata | output | 8 | Write byte |
| bus_rdata | input | 8 | Read byte, sampled at the handshake |
| done | output | 1 | One-cycle pulse after the last byte |
| rdata | output | 32 | Assembled read result |
| aligned | output | 1 | Access starts on an even physical address |

## Verification
The main sweep crosses eight segment values with eight offsets, all three sizes and both directions. The offsets near FFFFh separate in-segment offset wrap from a plain 20-bit increment. Segments near FFFFh exercise the wrap of the 20-bit sum. Odd and even offsets tell the alignment flag apart per size. Half the accesses stall the byte bus two cycles out of three, which checks that the address is held. A third of them keep a conflicting request asserted while busy, which checks that it is ignored. The read data is a function of the address, so a swapped, shifted or missing byte shows up in the assembled result.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } acc_size_t;

  // number of byte transfers for a size code, minus one
  function automatic logic [1:0] size_last_idx(input logic [1:0] code);
    case (acc_size_t'(code))
      SZ_WORD:  return 2'd1;
      SZ_DWORD: return 2'd3;
      default:  return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/seg_phys_addr.sv
module seg_phys_addr #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] phys
);
  logic [ADDR_W-1:0] seg_sh;
  logic [ADDR_W-1:0] off_ext;

  assign seg_sh  = {seg, {SHIFT{1'b0}}};
  assign off_ext = ADDR_W'(off);
  assign phys    = seg_sh + off_ext;   // wraps modulo 2^ADDR_W
endmodule

// File: rtl/seg_xfer_ctrl.sv
module seg_xfer_ctrl #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] last_idx,
  input  logic             bus_ready,
  output logic             busy,
  output logic             fire,
  output logic [IDX_W-1:0] idx,
  output logic             done
);
  logic at_last;

  assign fire    = busy && bus_ready;
  assign at_last = (idx == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      done <= fire && at_last;
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (fire) begin
        if (at_last) busy <= 1'b0;
        else         idx  <= idx + 1'b1;
      end
    end
  end

  // R6: a stalled transfer keeps its byte index
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_ready) |=> (busy && $stable(idx)));

  // R8: done is a single-cycle pulse, seen with the block idle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/seg_read_pack.sv
module seg_read_pack #(
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 4,
  localparam int IDX_W  = $clog2(MAX_BYTES),
  localparam int DATA_W = BYTE_W * MAX_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [DATA_W-1:0] result
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      result <= '0;
    else if (clear)  result <= '0;
    else if (take)   result[idx*BYTE_W +: BYTE_W] <= byte_in;
  end

  // R5: the result only moves on a clear or a taken read byte
  p_result_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !take) |=> $stable(result));
endmodule

// File: rtl/seg_access_seq.sv
module seg_access_seq #(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SHIFT     = 4,
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 4,
  localparam int ADDR_W = SEG_W + SHIFT,
  localparam int DATA_W = BYTE_W * MAX_BYTES,
  localparam int IDX_W  = $clog2(MAX_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_write,
  output logic [BYTE_W-1:0] bus_wdata,
  input  logic [BYTE_W-1:0] bus_rdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              aligned
);
  import seg_pkg::*;

  logic              busy;
  logic              fire;
  logic              start;
  logic [IDX_W-1:0]  idx;
  logic [SEG_W-1:0]  seg_q;
  logic [OFF_W-1:0]  off_q;
  logic [OFF_W-1:0]  cur_off;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [IDX_W-1:0]  last_q;
  logic [IDX_W-1:0]  req_last;
  logic [ADDR_W-1:0] req_phys;
  logic              aligned_q;

  assign req_ready = !busy;
  assign start     = req_valid && req_ready;
  assign req_last  = IDX_W'(size_last_idx(req_size));

  // first-byte address of the incoming request, for the alignment flag
  seg_phys_addr #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_req_addr (
    .seg  (req_seg),
    .off  (req_off),
    .phys (req_phys)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q     <= '0;
      off_q     <= '0;
      wr_q      <= 1'b0;
      wdata_q   <= '0;
      last_q    <= '0;
      aligned_q <= 1'b1;
    end else if (start) begin
      seg_q     <= req_seg;
      off_q     <= req_off;
      wr_q      <= req_write;
      wdata_q   <= req_wdata;
      last_q    <= req_last;
      aligned_q <= (req_last == '0) ? 1'b1 : !req_phys[0];
    end
  end

  seg_xfer_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .last_idx  (last_q),
    .bus_ready (bus_ready),
    .busy      (busy),
    .fire      (fire),
    .idx       (idx),
    .done      (done)
  );

  // later bytes advance the offset; it wraps inside the segment
  assign cur_off = off_q + OFF_W'(idx);

  seg_phys_addr #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_bus_addr (
    .seg  (seg_q),
    .off  (cur_off),
    .phys (bus_addr)
  );

  assign bus_valid = busy;
  assign bus_write = wr_q;
  assign bus_wdata = wdata_q[idx*BYTE_W +: BYTE_W];

  seg_read_pack #(.BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES)) u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start),
    .take    (fire && !wr_q),
    .idx     (idx),
    .byte_in (bus_rdata),
    .result  (rdata)
  );

  assign aligned = aligned_q;

  // R3: each non-final handshake moves the offset on by exactly one
  p_off_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (idx != last_q)) |=> (cur_off == $past(cur_off) + OFF_W'(1)));

  // R6: a stalled byte keeps its address and write byte
  p_bus_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> ($stable(bus_addr) && $stable(bus_wdata)));

  // R7: nothing latched from the request side while busy
  p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> ($stable(seg_q) && $stable(off_q) && $stable(wdata_q)));

  // R9: the alignment flag changes only on an accept
  p_aligned_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(aligned));
endmodule

// File: tb/seg_access_seq_test.sv
module seg_access_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_seg = '0;
  logic [15:0] req_off = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        bus_valid;
  logic        bus_ready = 1'b0;
  logic [19:0] bus_addr;
  logic        bus_write;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata = '0;
  logic        done;
  logic [31:0] rdata;
  logic        aligned;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  seg_access_seq uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_seg(req_seg), .req_off(req_off), .req_size(req_size),
    .req_write(req_write), .req_wdata(req_wdata),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done(done), .rdata(rdata), .aligned(aligned)
  );

  function automatic logic [7:0] mem_byte(input logic [19:0] a);
    return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'h3C;
  endfunction

  function automatic logic [19:0] exp_addr(input logic [15:0] s, input logic [15:0] o, input int k);
    logic [15:0] ok;
    ok = o + 16'(k);
    return {s, 4'h0} + {4'h0, ok};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] s, input logic [15:0] o, input logic [1:0] sz,
                     input bit wr, input logic [31:0] wd, input bit stall, input bit noise);
    int n;
    int k;
    int cyc;
    logic [31:0] exp_rd;
    logic [19:0] a;
    bit rdy;
    n = (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 1;
    exp_rd = '0;
    @(negedge clk);
    req_valid = 1'b1; req_seg = s; req_off = o; req_size = sz;
    req_write = wr; req_wdata = wd;
    check("R7 ready when idle", {31'b0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    k = 0; cyc = 0;
    while (k < n) begin
      if (noise) begin
        req_valid = 1'b1; req_seg = ~s; req_off = ~o; req_wdata = ~wd; req_write = ~wr;
      end
      rdy = stall ? ((cyc % 3) == 2) : 1'b1;
      bus_ready = rdy;
      a = exp_addr(s, o, k);
      bus_rdata = mem_byte(bus_addr);
      check("R6 bus_valid while busy", {31'b0, bus_valid}, 32'd1);
      check("R7 not ready while busy", {31'b0, req_ready}, 32'd0);
      check(k == 0 ? "R1 first address" : "R3 next address", {12'b0, bus_addr}, {12'b0, a});
      check("R6 direction", {31'b0, bus_write}, {31'b0, wr});
      if (wr) check("R4 write byte", {24'b0, bus_wdata}, {24'b0, wd[8*k +: 8]});
      else exp_rd[8*k +: 8] = mem_byte(a);
      if (rdy && bus_valid) k++;
      @(negedge clk);
      cyc++;
      if (cyc > 64) break;
    end
    req_valid = 1'b0;
    bus_ready = 1'b0;
    check("R2 transfer count", k, n);
    check("R8 done after last", {31'b0, done}, 32'd1);
    check("R8 bus idle at done", {31'b0, bus_valid}, 32'd0);
    check("R8 ready at done", {31'b0, req_ready}, 32'd1);
    check("R5 read result", rdata, wr ? 32'd0 : exp_rd);
    check("R9 aligned", {31'b0, aligned},
          (n == 1) ? 32'd1 : {31'b0, ~exp_addr(s, o, 0)[0]});
    @(negedge clk);
    check("R8 done single cycle", {31'b0, done}, 32'd0);
    check("R9 aligned held", {31'b0, aligned},
          (n == 1) ? 32'd1 : {31'b0, ~exp_addr(s, o, 0)[0]});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles >= 190000 && !finished) begin
        errors++;
        $display("FAIL watchdog: got %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] segs [8];
    logic [15:0] offs [8];
    int i;
    segs = '{16'h0000, 16'h0001, 16'h1234, 16'h8000, 16'hA000, 16'hF000, 16'hFFFF, 16'h0ABC};
    offs = '{16'h0000, 16'h0001, 16'h0022, 16'h55FF, 16'h7FFF, 16'hFFFD, 16'hFFFE, 16'hFFFF};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 req_ready", {31'b0, req_ready}, 32'd1);
    check("R10 bus_valid", {31'b0, bus_valid}, 32'd0);
    check("R10 done", {31'b0, done}, 32'd0);
    check("R10 rdata", rdata, 32'd0);
    check("R10 aligned", {31'b0, aligned}, 32'd1);

    // R1 worked example: 1234:0022 -> 12362h
    run(16'h1234, 16'h0022, 2'd0, 1'b0, 32'h0, 1'b0, 1'b0);
    // R4 pointer store: A000:55FF at 00008h, aligned
    run(16'h0000, 16'h0008, 2'd2, 1'b1, 32'hA00055FF, 1'b0, 1'b0);
    // R3 offset wrap inside segment, with stalls
    run(16'h0100, 16'hFFFE, 2'd2, 1'b0, 32'h0, 1'b1, 1'b0);
    // R1 20-bit wrap
    run(16'hFFFF, 16'h000E, 2'd2, 1'b1, 32'h11223344, 1'b0, 1'b1);
    // R2 size code 3 acts as a byte
    run(16'h2000, 16'h0003, 2'd3, 1'b0, 32'h0, 1'b0, 1'b0);

    i = 0;
    for (int si = 0; si < 8; si++)
      for (int oi = 0; oi < 8; oi++)
        for (int sz = 0; sz < 3; sz++)
          for (int w = 0; w < 2; w++) begin
            run(segs[si], offs[oi], 2'(sz), w[0],
                32'hC0DE0000 ^ {segs[si], offs[oi]} ^ 32'(i * 32'h01010101),
                i[0], (i % 3) == 0);
            i++;
          end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule